// File: doc/BRIEF.md
# Breakpoint Acknowledge Controller

This block sits beside the instruction decoder of a CPU core whose exception vector table can be moved. Such a core cannot tell that a breakpoint was reached from the address of a vector fetch. The controller therefore watches the decoded word stream for a small range of reserved breakpoint opcodes. When one arrives, it stalls decode and announces the hit with a read in the processor's special (CPU) address space. The breakpoint number is encoded into that read's address.

How the read ends decides what happens next. A bus-error termination makes the controller request illegal-instruction exception processing. A normal data acknowledge makes it hand the returned word back to the pipeline as a replacement opcode, which then executes in place of the breakpoint. If the read is never terminated, a programmable watchdog limit turns the silence into a bus error. The bus protocol beyond a simple request/termination handshake, and the exception processing itself, belong to neighbouring logic.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: A decoded word (dec_valid_i high) is a breakpoint exactly when its value lies in 0x4848..0x484F. In the cycle after such a word is accepted, the read request rises. Any other value leaves every output unchanged.
- R2: While the read is outstanding, bus_req_o and bus_cpu_space_o are high. bus_addr_o carries the breakpoint number (opcode bits [2:0]) in bits [4:2] and zero in every other bit. The request stays high until a termination or a timeout is taken.
- R3: dec_stall_o is high from the cycle after the breakpoint is accepted until the controller is back in idle, and low otherwise.
- R4: A bus_err_i seen while waiting produces a single-cycle illegal_req_o pulse in the next cycle, with no injected opcode.
- R5: A bus_ack_i seen while waiting produces a single-cycle inj_valid_o pulse in the next cycle, with inj_opcode_o equal to the bus_data_i sampled with the acknowledge.
- R6: When bus_err_i and bus_ack_i arrive in the same waiting cycle, the error wins and no opcode is injected.
- R7: With limit L = timeout_lim_i (0 acts as 1), L waiting cycles without any termination give an illegal_req_o pulse. A termination in the L-th waiting cycle is still honoured.
- R8: The first decoded word accepted after an injection is never treated as a breakpoint, even if its value is in range. Breakpoint decoding resumes with the word after it.
- R9: bus_ack_i and bus_err_i have no effect while the controller is idle.
- R10: After reset, dec_stall_o, bus_req_o, bus_cpu_space_o, inj_valid_o and illegal_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | A decoded opcode is presented |
| dec_opcode_i | input | OP_W | Decoded opcode |
| timeout_lim_i | input | TMO_W | Waiting-cycle limit before a forced bus error |
| dec_stall_o | output | 1 | Hold decode |
| bus_req_o | output | 1 | Special-space read request |
| bus_cpu_space_o | output | 1 | Marks the request as a CPU-space cycle |
| bus_addr_o | output | ADDR_W | Read address carrying the breakpoint number |
| bus_ack_i | input | 1 | Normal data acknowledge |
| bus_err_i | input | 1 | Bus-error termination |
| bus_data_i | input | OP_W | Read data returned with the acknowledge |
| inj_valid_o | output | 1 | Replacement opcode strobe |
| inj_opcode_o | output | OP_W | Replacement opcode |
| illegal_req_o | output | 1 | Request for illegal-instruction exception processing |

## Verification
Two decisions can meet in one waiting cycle. The first is the two terminations arriving together. The second is a termination landing on the very cycle the watchdog limit runs out. The bench provokes the first by raising bus_err_i and bus_ack_i together, both in directed cases and in random draws, and expects the exception pulse without any injection. It provokes the second by placing an acknowledge or error exactly in the L-th waiting cycle, including L of 0 and 1, and expects the real termination to decide the outcome rather than the timeout.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_INJECT = 3'd3,
    ST_EXCEPT = 3'd4
  } bk_state_e;

  localparam int unsigned NUM_W = 3;

endpackage

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int unsigned OP_W    = 16,
  parameter logic [15:0] BASE_OP = 16'h4848
) (
  input  logic                          valid_i,
  input  logic [OP_W-1:0]               opcode_i,
  input  logic                          suppress_i,
  output logic                          hit_o,
  output logic [bkpt_pkg::NUM_W-1:0]    num_o
);
  import bkpt_pkg::*;

  localparam int unsigned HI_W = OP_W - NUM_W;

  logic [HI_W-1:0] base_hi;
  logic            range_hit;

  generate
    if (OP_W >= 16) begin : g_wide
      assign base_hi = HI_W'(BASE_OP[15:NUM_W]);
    end else begin : g_narrow
      assign base_hi = BASE_OP[OP_W-1:NUM_W];
    end
  endgenerate

  assign range_hit = (opcode_i[OP_W-1:NUM_W] == base_hi);
  assign hit_o     = valid_i && range_hit && !suppress_i;
  assign num_o     = opcode_i[NUM_W-1:0];

endmodule

// File: rtl/bkpt_timer.sv
module bkpt_timer #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             term_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W-1:0] lim_eff;
  logic             cnt_en;

  assign lim_eff  = (lim_i == '0) ? TMO_W'(1) : lim_i;
  assign expire_o = active_i && !term_i && (cnt_q == lim_eff - TMO_W'(1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!active_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!expire_o && !term_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + TMO_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bkpt_fsm.sv
module bkpt_fsm (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hit_i,
  input  logic                 dec_valid_i,
  input  logic                 ack_i,
  input  logic                 err_i,
  input  logic                 expire_i,
  output bkpt_pkg::bk_state_e  state_o,
  output logic                 suppress_o,
  output logic                 start_o,
  output logic                 take_data_o
);
  import bkpt_pkg::*;

  bk_state_e state_q, state_d;
  logic      supp_q, supp_d, supp_en;

  always_comb begin
    state_d     = state_q;
    start_o     = 1'b0;
    take_data_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit_i) begin
          state_d = ST_READ;
          start_o = 1'b1;
        end
      end
      ST_READ:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (err_i) begin
          state_d = ST_EXCEPT;
        end else if (ack_i) begin
          state_d     = ST_INJECT;
          take_data_o = 1'b1;
        end else if (expire_i) begin
          state_d = ST_EXCEPT;
        end
      end
      ST_INJECT: state_d = ST_IDLE;
      ST_EXCEPT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    supp_en = 1'b0;
    supp_d  = supp_q;
    if (state_q == ST_INJECT) begin
      supp_en = 1'b1;
      supp_d  = 1'b1;
    end else if (state_q == ST_IDLE && dec_valid_i && supp_q) begin
      supp_en = 1'b1;
      supp_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      supp_q <= 1'b0;
    end else if (supp_en) begin
      supp_q <= supp_d;
    end
  end

  assign state_o    = state_q;
  assign suppress_o = supp_q;

endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl #(
  parameter int unsigned OP_W    = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TMO_W   = 8,
  parameter logic [15:0] BASE_OP = 16'h4848
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [OP_W-1:0]   dec_opcode_i,
  input  logic [TMO_W-1:0]  timeout_lim_i,
  output logic              dec_stall_o,
  output logic              bus_req_o,
  output logic              bus_cpu_space_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [OP_W-1:0]   bus_data_i,
  output logic              inj_valid_o,
  output logic [OP_W-1:0]   inj_opcode_o,
  output logic              illegal_req_o
);
  import bkpt_pkg::*;

  localparam int unsigned NUM_LSB = 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_n;
  assign rst_n = rst_s2_q;

  bk_state_e            state;
  logic                 hit, suppress, start, take_data, expire, in_wait;
  logic [NUM_W-1:0]     num_w, num_q;
  logic [OP_W-1:0]      data_q;

  bkpt_match #(.OP_W(OP_W), .BASE_OP(BASE_OP)) u_match (
    .valid_i    (dec_valid_i),
    .opcode_i   (dec_opcode_i),
    .suppress_i (suppress),
    .hit_o      (hit),
    .num_o      (num_w)
  );

  assign in_wait = (state == ST_WAIT);

  bkpt_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .active_i (in_wait),
    .term_i   (bus_ack_i || bus_err_i),
    .lim_i    (timeout_lim_i),
    .expire_o (expire)
  );

  bkpt_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .hit_i       (hit),
    .dec_valid_i (dec_valid_i),
    .ack_i       (bus_ack_i),
    .err_i       (bus_err_i),
    .expire_i    (expire),
    .state_o     (state),
    .suppress_o  (suppress),
    .start_o     (start),
    .take_data_o (take_data)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (start) begin
      num_q <= num_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take_data) begin
      data_q <= bus_data_i;
    end
  end

  logic outstanding;
  assign outstanding = (state == ST_READ) || (state == ST_WAIT);

  always_comb begin
    bus_addr_o = '0;
    if (outstanding) begin
      bus_addr_o[NUM_LSB +: NUM_W] = num_q;
    end
  end

  assign bus_req_o       = outstanding;
  assign bus_cpu_space_o = outstanding;
  assign dec_stall_o     = (state != ST_IDLE);
  assign inj_valid_o     = (state == ST_INJECT);
  assign inj_opcode_o    = (state == ST_INJECT) ? data_q : '0;
  assign illegal_req_o   = (state == ST_EXCEPT);

endmodule

// File: rtl/bkpt_ack_ctrl_chk.sv
module bkpt_ack_ctrl_chk #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_stall_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              bus_err_i,
  input logic              inj_valid_o,
  input logic              illegal_req_o,
  input bkpt_pkg::bk_state_e state
);
  import bkpt_pkg::*;

  a_r4_exc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_req_o |=> !illegal_req_o);

  a_r5_inj_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_o |=> !inj_valid_o);

  a_r6_no_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inj_valid_o && illegal_req_o));

  a_r6_err_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && bus_err_i) |=> (illegal_req_o && !inj_valid_o));

  a_r2_addr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[1:0] == 2'b00 && (bus_addr_o >> 5) == '0));

  a_r3_stall_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> dec_stall_o);

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && !bus_ack_i && !bus_err_i && !$past(bus_req_o, 1) == 1'b0
     && !illegal_req_o) |-> bus_req_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |=> (!inj_valid_o && !illegal_req_o));

endmodule

bind bkpt_ack_ctrl bkpt_ack_ctrl_chk #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_n),
  .dec_stall_o   (dec_stall_o),
  .bus_req_o     (bus_req_o),
  .bus_addr_o    (bus_addr_o),
  .bus_ack_i     (bus_ack_i),
  .bus_err_i     (bus_err_i),
  .inj_valid_o   (inj_valid_o),
  .illegal_req_o (illegal_req_o),
  .state         (state)
);

// File: tb/bkpt_ack_ctrl_bench.sv
`timescale 1ns/1ps
module bkpt_ack_ctrl_bench;
  localparam int OP_W = 16, ADDR_W = 32, TMO_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid;
  logic [OP_W-1:0] dec_op;
  logic [TMO_W-1:0] lim;
  logic stall, req, cpu_sp, ack, err, inj_v, illeg;
  logic [ADDR_W-1:0] addr;
  logic [OP_W-1:0] bdata, inj_op;

  int total = 0, bad = 0;
  bit supp_model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bkpt_ack_ctrl u_bkpt_ack_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_opcode_i(dec_op),
    .timeout_lim_i(lim), .dec_stall_o(stall), .bus_req_o(req),
    .bus_cpu_space_o(cpu_sp), .bus_addr_o(addr), .bus_ack_i(ack),
    .bus_err_i(err), .bus_data_i(bdata), .inj_valid_o(inj_v),
    .inj_opcode_o(inj_op), .illegal_req_o(illeg));

  function automatic bit in_range(logic [15:0] op);
    return op >= 16'h4848 && op <= 16'h484F;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(logic [15:0] op);
    return ADDR_W'({op[2:0], 2'b00});
  endfunction

  function automatic int lim_eff(logic [TMO_W-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // kind: 0 ack, 1 err, 2 both, 3 no termination
  task automatic run_case(logic [15:0] op, int kind, int dly, logic [15:0] data,
                          logic [TMO_W-1:0] l);
    int n;
    bit hit;
    lim = l;
    hit = in_range(op) && !supp_model;
    dec_valid = 1; dec_op = op;
    step();
    dec_valid = 0;
    if (!hit) begin
      chk(!stall && !req && !inj_v && !illeg, supp_model ? "R8 suppressed" : "R1 non-bkpt",
          {stall, req, inj_v, illeg}, 0);
      supp_model = 0;
      return;
    end
    supp_model = 0;
    chk(req && cpu_sp, "R1 req rise", {req, cpu_sp}, 2'b11);
    chk(addr == exp_addr(op), "R2 addr", addr, exp_addr(op));
    chk(stall, "R3 stall", stall, 1);
    step();
    n = (kind == 3) ? lim_eff(l) : dly + 1;
    for (int j = 0; j < n; j++) begin
      if (j == n - 1 && kind != 3) begin
        ack = (kind == 0 || kind == 2);
        err = (kind == 1 || kind == 2);
        bdata = data;
      end
      step();
      ack = 0; err = 0; bdata = $urandom;
      if (j < n - 1)
        chk(req && stall && !inj_v && !illeg, "R2 req held", {req, stall, inj_v, illeg}, 4'b1100);
    end
    if (kind == 0) begin
      chk(inj_v && !illeg && inj_op == data, "R5 inject", {inj_v, illeg, inj_op}, {2'b10, data});
      supp_model = 1;
    end else begin
      chk(illeg && !inj_v, kind == 2 ? "R6 err wins" : (kind == 3 ? "R7 timeout" : "R4 err"),
          {illeg, inj_v}, 2'b10);
    end
    chk(stall && !req, "R3 stall in result cycle", {stall, req}, 2'b10);
    step();
    chk(!stall && !inj_v && !illeg, "R4 R5 single pulse", {stall, inj_v, illeg}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; dec_valid = 0; dec_op = 0; lim = 4; ack = 0; err = 0; bdata = 0;
    repeat (3) step();
    chk(!stall && !req && !cpu_sp && !inj_v && !illeg, "R10 reset",
        {stall, req, cpu_sp, inj_v, illeg}, 0);
    rst_n = 1;
    repeat (4) step();
    chk(!stall && !req && !inj_v && !illeg, "R10 after release", {stall, req, inj_v, illeg}, 0);

    // R9: terminations in idle
    ack = 1; err = 1; bdata = 16'hBEEF;
    step(); step();
    ack = 0; err = 0;
    chk(!stall && !inj_v && !illeg, "R9 idle terms", {stall, inj_v, illeg}, 0);

    // R1 boundaries
    run_case(16'h4847, 0, 0, 16'h1111, 4);
    run_case(16'h4850, 0, 0, 16'h1111, 4);
    run_case(16'h4848, 0, 0, 16'h4E71, 4);
    // R8: injected word in range is suppressed, next one is not
    run_case(16'h484F, 0, 2, 16'h2222, 4);
    run_case(16'h484F, 1, 1, 16'h0, 4);
    run_case(16'h484B, 1, 0, 16'h0, 4);
    run_case(16'h484C, 2, 1, 16'h3333, 4);
    // R7 corners
    run_case(16'h484D, 3, 0, 16'h0, 3);
    run_case(16'h484E, 3, 0, 16'h0, 0);
    run_case(16'h4849, 0, 0, 16'h4444, 0);
    run_case(16'h484A, 0, 4, 16'h5555, 5);
    run_case(16'h1234, 0, 0, 16'h0, 5);
    run_case(16'h484A, 1, 1, 16'h0, 2);
    run_case(16'h484A, 2, 0, 16'h0, 1);

    for (int i = 0; i < 200; i++) begin
      logic [15:0] op;
      logic [TMO_W-1:0] l;
      int kind, d;
      op = ($urandom % 4 == 0) ? 16'($urandom) : 16'h4846 + 16'($urandom % 12);
      l = TMO_W'($urandom % 7);
      kind = $urandom % 4;
      d = $urandom % lim_eff(l);
      run_case(op, kind, d, 16'($urandom), l);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule